// File: doc/BRIEF.md
# Video-Priority Memory Request Arbiter

This block sits in front of a memory controller and decides which of three requesters gets the next memory burst. The three are a system-bus port and two video DMA ports: one feeds a display panel and the other a monitor output. Each port has its own address input and its own request and acknowledge pair. Read data returns on two buses. The system-bus port has a data bus of its own. Both video ports share one data bus, and a separate data-valid strobe for each port tells them apart.

A decision is made only while no burst is in progress. A pending video request always beats the system-bus request. When both video ports are pending, the panel wins unless the last video burst went to the panel. In that case the monitor wins, so neither video port can starve. Once a burst is granted it runs for a fixed number of beats. The memory side marks each beat with a strobe and can stall a beat by holding that strobe low. A system-bus requester that keeps its request raised for a long time therefore never delays video by more than the remainder of one burst.

Top module: `vid_mem_arb`

## Requirements
- R1: After reset all acknowledges, all data-valid strobes and `burst_busy` are 0, and `mem_addr` is 0.
- R2: At a decision point where any video request is pending, the system-bus port is not acknowledged.
- R3: When both video requests are pending at a decision point and the previous video grant went to the monitor (or no video grant has been made since reset), the panel port is acknowledged.
- R4: When both video requests are pending at a decision point and the previous video grant went to the panel, the monitor port is acknowledged.
- R5: The system-bus port is acknowledged only if its request was high and neither video request was high at the decision point.
- R6: A decision on an idle cycle produces, on the next cycle, a one-cycle acknowledge to exactly one requester. At most one acknowledge is high in any cycle.
- R7: The acknowledge cycle is the first cycle in which `burst_busy` is high. No acknowledge is issued while a burst is in progress.
- R8: `mem_addr` takes the winner's address in the acknowledge cycle and holds it for the whole burst.
- R9: Each cycle with `burst_busy` and `mem_beat` both high produces, one cycle later, the owner's data-valid strobe. The data sampled in that beat appears on `sys_rdata` for the system-bus port and on `vid_rdata` for either video port. A burst delivers exactly BURST_LEN strobes.
- R10: With the memory giving a beat every cycle and the system-bus request held high, a video request raised while the other video port is idle is acknowledged within BURST_LEN+1 cycles. If it is raised in the acknowledge cycle of a system-bus burst, it is acknowledged exactly BURST_LEN+1 cycles later.
- R11: A cycle with `mem_beat` low during a burst is not counted. It extends the burst by one cycle and produces no data-valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_req | input | 1 | System-bus port wants a burst |
| sys_addr | input | AW | System-bus burst address |
| sys_ack | output | 1 | One-cycle grant to the system-bus port |
| pnl_req | input | 1 | Panel video port wants a burst |
| pnl_addr | input | AW | Panel burst address |
| pnl_ack | output | 1 | One-cycle grant to the panel port |
| mon_req | input | 1 | Monitor video port wants a burst |
| mon_addr | input | AW | Monitor burst address |
| mon_ack | output | 1 | One-cycle grant to the monitor port |
| mem_beat | input | 1 | Memory delivers one halfword this cycle |
| mem_rdata | input | DW | Halfword from memory |
| mem_addr | output | AW | Selected burst address toward the memory controller |
| burst_busy | output | 1 | A granted burst is in progress |
| sys_rdata | output | DW | Read data for the system-bus port |
| sys_dv | output | 1 | `sys_rdata` holds a new halfword |
| vid_rdata | output | DW | Shared read data for both video ports |
| pnl_dv | output | 1 | `vid_rdata` holds a panel halfword |
| mon_dv | output | 1 | `vid_rdata` holds a monitor halfword |

## Verification
The assertions assume that a requester keeps its request level high until it sees its acknowledge. A high request level after the acknowledge is treated as a fresh request for another burst. They also assume that `mem_beat` means something only while `burst_busy` is high. The bench drives every input at the falling edge. It lowers a request in the cycle it sees that request's acknowledge, unless the scenario is deliberately asking for back-to-back bursts. It applies stall patterns only through `mem_beat`. The expected winner is tracked in the bench from the rotation rule, including the last video grant carried over from earlier scenarios.

// File: rtl/vma_pkg.sv
// Package: shared source encoding for the video-priority arbiter.
// Assumes: exactly three requesters; SRC_NONE marks an idle decision.
package vma_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SYS  = 2'd1,
        SRC_PNL  = 2'd2,
        SRC_MON  = 2'd3
    } src_e;
endpackage

// File: rtl/vma_pick.sv
// Module: vma_pick
// Purely combinational winner selection. Video beats the system bus;
// between the two video ports the panel wins unless it had the last
// video grant, in which case the monitor wins.
// Assumes: the caller only uses the result on an idle (decision) cycle.
module vma_pick
    import vma_pkg::*;
(
    input  logic sys_req,
    input  logic pnl_req,
    input  logic mon_req,
    input  logic last_was_pnl,
    output src_e winner
);
    // Priority with two-way rotation among the video ports.
    always_comb begin
        if (pnl_req && mon_req)
            winner = last_was_pnl ? SRC_MON : SRC_PNL;
        else if (pnl_req)
            winner = SRC_PNL;
        else if (mon_req)
            winner = SRC_MON;
        else if (sys_req)
            winner = SRC_SYS;
        else
            winner = SRC_NONE;
    end
endmodule

// File: rtl/vma_burst_ctr.sv
// Module: vma_burst_ctr
// Tracks one burst: goes busy on start and counts accepted beats,
// leaving busy after BURST_LEN of them.
// Assumes: start is only raised while not busy; BURST_LEN >= 2.
module vma_burst_ctr #(
    parameter int BURST_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic beat,
    output logic busy
);
    localparam int CW = $clog2(BURST_LEN);
    localparam logic [CW-1:0] LAST = CW'(BURST_LEN - 1);

    logic [CW-1:0] cnt_q;

    // Busy flag and beat counter for the burst in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= '0;
        end else if (busy && beat) begin
            if (cnt_q == LAST) begin
                busy  <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vma_rdata_route.sv
// Module: vma_rdata_route
// Registers each accepted memory halfword onto the owner's data bus and
// raises that owner's valid strobe for one cycle.
// Assumes: beat_ok is only high during a burst with a real owner.
module vma_rdata_route
    import vma_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat_ok,
    input  src_e          owner,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] sys_rdata,
    output logic          sys_dv,
    output logic [DW-1:0] vid_rdata,
    output logic          pnl_dv,
    output logic          mon_dv
);
    logic is_vid;
    assign is_vid = (owner == SRC_PNL) || (owner == SRC_MON);

    // Per-owner valid strobes, one cycle after the beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_dv <= 1'b0;
            pnl_dv <= 1'b0;
            mon_dv <= 1'b0;
        end else begin
            sys_dv <= beat_ok && (owner == SRC_SYS);
            pnl_dv <= beat_ok && (owner == SRC_PNL);
            mon_dv <= beat_ok && (owner == SRC_MON);
        end
    end

    // Data capture: system bus and the shared video bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_rdata <= '0;
            vid_rdata <= '0;
        end else if (beat_ok) begin
            if (is_vid) vid_rdata <= mem_rdata;
            else        sys_rdata <= mem_rdata;
        end
    end
endmodule

// File: rtl/vid_mem_arb.sv
// Module: vid_mem_arb (top)
// Front-end arbiter of a memory controller for one system-bus port and
// two video DMA ports. Decides only between bursts, grants with a
// one-cycle acknowledge, latches the winner's address and routes the
// returned halfwords.
// Assumes: requesters hold req until their ack; memory marks each beat
// with mem_beat during burst_busy.
module vid_mem_arb
    import vma_pkg::*;
#(
    parameter int AW        = 24,
    parameter int DW        = 16,
    parameter int BURST_LEN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sys_req,
    input  logic [AW-1:0] sys_addr,
    output logic          sys_ack,
    input  logic          pnl_req,
    input  logic [AW-1:0] pnl_addr,
    output logic          pnl_ack,
    input  logic          mon_req,
    input  logic [AW-1:0] mon_addr,
    output logic          mon_ack,
    input  logic          mem_beat,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          burst_busy,
    output logic [DW-1:0] sys_rdata,
    output logic          sys_dv,
    output logic [DW-1:0] vid_rdata,
    output logic          pnl_dv,
    output logic          mon_dv
);
    src_e          winner;
    src_e          owner_q;
    logic          last_pnl_q;
    logic          decide;
    logic [AW-1:0] win_addr;

    vma_pick u_pick (
        .sys_req      (sys_req),
        .pnl_req      (pnl_req),
        .mon_req      (mon_req),
        .last_was_pnl (last_pnl_q),
        .winner       (winner)
    );

    assign decide = !burst_busy && (winner != SRC_NONE);

    vma_burst_ctr #(.BURST_LEN(BURST_LEN)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (decide),
        .beat  (mem_beat),
        .busy  (burst_busy)
    );

    // Address mux steered by the winner.
    always_comb begin
        case (winner)
            SRC_PNL: win_addr = pnl_addr;
            SRC_MON: win_addr = mon_addr;
            SRC_SYS: win_addr = sys_addr;
            default: win_addr = '0;
        endcase
    end

    // Grant registers: owner, address, acks and video rotation memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q    <= SRC_NONE;
            mem_addr   <= '0;
            sys_ack    <= 1'b0;
            pnl_ack    <= 1'b0;
            mon_ack    <= 1'b0;
            last_pnl_q <= 1'b0;
        end else begin
            sys_ack <= decide && (winner == SRC_SYS);
            pnl_ack <= decide && (winner == SRC_PNL);
            mon_ack <= decide && (winner == SRC_MON);
            if (decide) begin
                owner_q  <= winner;
                mem_addr <= win_addr;
                if (winner == SRC_PNL) last_pnl_q <= 1'b1;
                if (winner == SRC_MON) last_pnl_q <= 1'b0;
            end
        end
    end

    vma_rdata_route #(.DW(DW)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_ok   (burst_busy && mem_beat),
        .owner     (owner_q),
        .mem_rdata (mem_rdata),
        .sys_rdata (sys_rdata),
        .sys_dv    (sys_dv),
        .vid_rdata (vid_rdata),
        .pnl_dv    (pnl_dv),
        .mon_dv    (mon_dv)
    );
endmodule

// File: rtl/vid_mem_arb_chk.sv
// Module: vid_mem_arb_chk
// Property checker for vid_mem_arb, attached by bind below.
// Assumes: requesters hold req until ack.
module vid_mem_arb_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sys_req,
    input logic          pnl_req,
    input logic          mon_req,
    input logic          sys_ack,
    input logic          pnl_ack,
    input logic          mon_ack,
    input logic          burst_busy,
    input logic          mem_beat,
    input logic [AW-1:0] mem_addr,
    input logic          sys_dv,
    input logic          pnl_dv,
    input logic          mon_dv
);
    logic any_ack;
    logic any_dv;
    assign any_ack = sys_ack || pnl_ack || mon_ack;
    assign any_dv  = sys_dv || pnl_dv || mon_dv;

    a_r6_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sys_ack, pnl_ack, mon_ack}));

    a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        any_ack |=> !any_ack);

    a_r7_ack_opens_burst: assert property (@(posedge clk) disable iff (!rst_n)
        any_ack |-> (burst_busy && !$past(burst_busy)));

    a_r2_video_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_busy && (pnl_req || mon_req)) |=> !sys_ack);

    a_r5_sys_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sys_ack |-> $past(sys_req && !pnl_req && !mon_req));

    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_busy && !any_ack) |-> $stable(mem_addr));

    a_r9_dv_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sys_dv, pnl_dv, mon_dv}));

    a_r11_dv_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
        any_dv |-> $past(burst_busy && mem_beat));
endmodule

bind vid_mem_arb vid_mem_arb_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_req    (sys_req),
    .pnl_req    (pnl_req),
    .mon_req    (mon_req),
    .sys_ack    (sys_ack),
    .pnl_ack    (pnl_ack),
    .mon_ack    (mon_ack),
    .burst_busy (burst_busy),
    .mem_beat   (mem_beat),
    .mem_addr   (mem_addr),
    .sys_dv     (sys_dv),
    .pnl_dv     (pnl_dv),
    .mon_dv     (mon_dv)
);

// File: tb/vid_mem_arb_tb_top.sv
// Directed bench for vid_mem_arb: one task per scenario, each checks itself.
module vid_mem_arb_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int BL = 8;

    localparam int W_NONE = 0;
    localparam int W_SYS  = 1;
    localparam int W_PNL  = 2;
    localparam int W_MON  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sys_req = 1'b0, pnl_req = 1'b0, mon_req = 1'b0;
    logic [AW-1:0] sys_addr = '0, pnl_addr = '0, mon_addr = '0;
    logic          sys_ack, pnl_ack, mon_ack;
    logic          mem_beat = 1'b1;
    logic [DW-1:0] mem_rdata = '0;
    logic [AW-1:0] mem_addr;
    logic          burst_busy;
    logic [DW-1:0] sys_rdata, vid_rdata;
    logic          sys_dv, pnl_dv, mon_dv;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    bit last_pnl = 1'b0;   // bench model of the rotation state

    vid_mem_arb #(.AW(AW), .DW(DW), .BURST_LEN(BL)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .sys_req(sys_req), .sys_addr(sys_addr), .sys_ack(sys_ack),
        .pnl_req(pnl_req), .pnl_addr(pnl_addr), .pnl_ack(pnl_ack),
        .mon_req(mon_req), .mon_addr(mon_addr), .mon_ack(mon_ack),
        .mem_beat(mem_beat), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .burst_busy(burst_busy),
        .sys_rdata(sys_rdata), .sys_dv(sys_dv),
        .vid_rdata(vid_rdata), .pnl_dv(pnl_dv), .mon_dv(mon_dv)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int who_acked();
        if (sys_ack) return W_SYS;
        if (pnl_ack) return W_PNL;
        if (mon_ack) return W_MON;
        return W_NONE;
    endfunction

    function automatic logic [AW-1:0] addr_of(input int w);
        if (w == W_SYS) return sys_addr;
        if (w == W_PNL) return pnl_addr;
        if (w == W_MON) return mon_addr;
        return '0;
    endfunction

    // Step falling edges until an ack; check winner, address, busy (R6/R7/R8).
    task automatic wait_ack(input int exp_w, input int maxc, input string tag, output int lat);
        int w;
        lat = 0;
        w = W_NONE;
        while (lat < maxc && w == W_NONE) begin
            @(negedge clk);
            lat++;
            w = who_acked();
        end
        check(w == exp_w, {tag, " winner"}, w, exp_w);
        check(burst_busy == 1'b1, "R7 busy in ack cycle", burst_busy, 1);
        check(mem_addr == addr_of(exp_w), "R8 mem_addr latched", mem_addr, addr_of(exp_w));
        if (exp_w == W_PNL) last_pnl = 1'b1;
        if (exp_w == W_MON) last_pnl = 1'b0;
    endtask

    // Run the burst in progress; stall_every>0 drops mem_beat periodically (R9/R11).
    task automatic run_burst(input int owner, input int stall_every, input logic [DW-1:0] base);
        int got = 0;
        int i = 0;
        logic [AW-1:0] a0;
        a0 = mem_addr;
        while (burst_busy && i < 200) begin
            logic b;
            logic pb;
            logic [DW-1:0] d;
            b  = (stall_every > 0) ? ((i % stall_every) != stall_every - 1) : 1'b1;
            d  = base + DW'(i);
            pb = burst_busy;
            mem_beat  = b;
            mem_rdata = d;
            @(negedge clk);
            i++;
            begin
                bit exp_dv;
                exp_dv = pb && b;
                check((owner == W_SYS ? sys_dv : owner == W_PNL ? pnl_dv : mon_dv) == exp_dv,
                      "R11 dv follows accepted beat", exp_dv ? 0 : 1, exp_dv);
                if (exp_dv) begin
                    got++;
                    if (owner == W_SYS)
                        check(sys_rdata == d, "R9 sys data", sys_rdata, d);
                    else
                        check(vid_rdata == d, "R9 video data", vid_rdata, d);
                end
            end
            if (burst_busy) begin
                check(who_acked() == W_NONE, "R7 no ack mid-burst", who_acked(), W_NONE);
                check(mem_addr == a0, "R8 address held", mem_addr, a0);
            end
        end
        check(got == BL, "R9 strobes per burst", got, BL);
        mem_beat = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check({sys_ack, pnl_ack, mon_ack} == 3'b000, "R1 acks low", {sys_ack, pnl_ack, mon_ack}, 0);
        check(burst_busy == 1'b0, "R1 busy low", burst_busy, 0);
        check({sys_dv, pnl_dv, mon_dv} == 3'b000, "R1 dv low", {sys_dv, pnl_dv, mon_dv}, 0);
        check(mem_addr == '0, "R1 addr zero", mem_addr, 0);
        rst_n = 1'b1;
        last_pnl = 1'b0;
        @(negedge clk);
    endtask

    // R5/R6: lone system-bus request is granted on the next cycle.
    task automatic t_sys_alone();
        int lat;
        sys_addr = 24'h00A100;
        sys_req  = 1'b1;
        wait_ack(W_SYS, 4, "R5 sys alone", lat);
        check(lat == 1, "R6 ack one cycle after idle decision", lat, 1);
        sys_req = 1'b0;
        run_burst(W_SYS, 0, 16'h1000);
        @(negedge clk);
        check(who_acked() == W_NONE, "R6 no ack without request", who_acked(), W_NONE);
    endtask

    // R2: simultaneous system and panel requests; panel first, then system.
    task automatic t_video_over_sys();
        int lat;
        sys_addr = 24'h00B200;
        pnl_addr = 24'h00C300;
        sys_req = 1'b1;
        pnl_req = 1'b1;
        wait_ack(W_PNL, 4, "R2 video beats sys", lat);
        pnl_req = 1'b0;
        run_burst(W_PNL, 0, 16'h2000);
        wait_ack(W_SYS, 4, "R5 sys after video", lat);
        sys_req = 1'b0;
        run_burst(W_SYS, 0, 16'h2100);
    endtask

    // R3/R4: both video held plus sys held; alternation, sys waits.
    task automatic t_rotation();
        int lat;
        pnl_addr = 24'h00D400;
        mon_addr = 24'h00E500;
        sys_req = 1'b1;
        pnl_req = 1'b1;
        mon_req = 1'b1;
        for (int k = 0; k < 4; k++) begin
            int exp_w;
            exp_w = last_pnl ? W_MON : W_PNL;
            wait_ack(exp_w, 4, last_pnl ? "R4 monitor after panel" : "R3 panel first", lat);
            run_burst(exp_w, 0, 16'h3000 + DW'(k * 16));
        end
        pnl_req = 1'b0;
        mon_req = 1'b0;
        wait_ack(W_SYS, 4, "R5 sys once video clear", lat);
        sys_req = 1'b0;
        run_burst(W_SYS, 0, 16'h3100);
    endtask

    // R10: sys held continuously; video raised at several burst offsets.
    task automatic t_latency();
        int lat;
        sys_addr = 24'h00F600;
        mon_addr = 24'h00F700;
        sys_req = 1'b1;
        for (int off = 0; off < 3; off++) begin
            wait_ack(W_SYS, 2 * BL + 4, "R10 sys burst", lat);
            repeat (off * 3) @(negedge clk);
            mon_req = 1'b1;
            wait_ack(W_MON, 2 * BL + 4, "R10 video under sys load", lat);
            check(lat <= BL + 1 - off * 3, "R10 video latency bound", lat, BL + 1 - off * 3);
            if (off == 0) check(lat == BL + 1, "R10 exact latency", lat, BL + 1);
            mon_req = 1'b0;
            run_burst(W_MON, 0, 16'h4000 + DW'(off * 16));
        end
        wait_ack(W_SYS, 4, "R5 sys resumes", lat);
        sys_req = 1'b0;
        run_burst(W_SYS, 0, 16'h4100);
    endtask

    // R11: stalled beats extend a burst; video request waits without early ack.
    task automatic t_stall();
        int lat;
        int len;
        sys_addr = 24'h001800;
        pnl_addr = 24'h001900;
        sys_req = 1'b1;
        wait_ack(W_SYS, 4, "R11 sys grant", lat);
        sys_req = 1'b0;
        pnl_req = 1'b1;
        len = 0;
        run_burst(W_SYS, 3, 16'h5000);
        wait_ack(W_PNL, 4, "R11 panel after stalled burst", lat);
        check(lat == 1, "R11 panel on first idle decision", lat, 1);
        pnl_req = 1'b0;
        run_burst(W_PNL, 2, 16'h5100);
        repeat (3) @(negedge clk);
        check(burst_busy == 1'b0, "R7 idle with no requests", burst_busy, 0);
    endtask

    initial begin
        t_reset();
        t_sys_alone();
        t_video_over_sys();
        t_rotation();
        t_latency();
        t_stall();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule